// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects many level-sensitive interrupt sources and presents one request to a processor core. Every source takes its 4-bit priority level from a field in a small set of priority registers. Related sources, such as the four requests of a serial unit or all the completion requests of a DMA engine, share one field and so always carry the same level.

Per-source masking is held in a mask register. It has two write addresses: one sets mask bits and one clears them, so software never needs a read-modify-write. Each cycle the controller finds the pending, unmasked source with the highest non-zero level. It registers that level and the source's fixed 12-bit event code, and raises the request only when the level is strictly above the core's current mask level.

Build-time parameters choose between four and eight DMA completion sources and add or remove two extra timer sources. The source index order is fixed, and it is also the tie-break order.

Top module: `gpic_top`

## Requirements
- R1: After reset, irq_req, irq_level and irq_code are 0, every priority field is 0, the mask register is 0, and every register reads back 0.
- R2: Registers at addresses 0, 1 and 2 are 16 bits wide. Field k sits in bits [4k+3:4k] for k = 0 to 3. Write data bits 31:16 are ignored, and reads return 0 there.
- R3: The register at address 3 is 32 bits wide with eight 4-bit fields. A field that no source uses, including fields 1 to 3 at address 2, ignores writes and reads back 0.
- R4: Sources are numbered as follows, with the field they use (address.field) and their event code:
  - 0 to 3: external lines, fields 0.0 to 0.3, codes 0x240, 0x2A0, 0x300 and 0x360.
  - 4 to 6: timers, fields 1.0 to 1.2, codes 0x400, 0x420 and 0x440.
  - 7 to 10: the serial group, which shares field 1.3, codes 0x4E0 to 0x540 in steps of 0x20.
  - 11 up: the DMA group, which shares field 2.0, codes 0x640 to 0x6A0, then 0x780 to 0x7E0 when there are eight sources.
  - The next two: extra timers, fields 3.0 and 3.1, codes 0xB00 and 0xB80.
- R5: Writing address 4 sets every mask bit whose write-data bit is 1. Writing address 5 clears every mask bit whose write-data bit is 1. Zero bits leave the mask unchanged, and both addresses read the mask in bits [N-1:0]. A masked source cannot win.
- R6: A source whose level is 0 can never win. When no source is eligible, irq_level and irq_code are 0 and irq_req is 0.
- R7: Among pending, unmasked sources with a non-zero level, the highest level wins. On a tie, the lowest source index wins.
- R8: irq_req is 1 only when the winning level is strictly greater than cpu_mask. irq_level and irq_code show the winner whatever cpu_mask is.
- R9: The outputs are registered. They reflect src_lvl and cpu_mask one clock edge after those inputs change. A register write takes effect at its edge and reaches the outputs at the edge after that.
- R10: DMA_CH (4 or 8) sets the number of DMA sources, and EXTRA_TMR (0 or 1) adds the two extra timer sources. The default build has 17 sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address (0-3 priority, 4 mask set, 5 mask clear) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| src_lvl | input | N | Level-sensitive source requests, one bit per source index |
| cpu_mask | input | 4 | Core's current interrupt mask level |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | 4 | Level of the winning source |
| irq_code | output | 12 | Event code of the winning source |

## Verification
The bench sweeps every source of the default build alone and checks each event code against the table in R4. A wrong entry or an off-by-one in the index would show up as a wrong code. It then drives two members of one group after a single field write: a design that failed to share the field would report the old level for one of them. Ties at equal level, level-zero sources, and a cpu_mask equal to the winning level are all aimed at, because a `>=` slipped in for `>` in either comparison changes the winner or raises a spurious request. A long randomized run against an arithmetic model covers masking, group sharing and the one-edge output latency together.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

  localparam int LVL_W  = 4;
  localparam int CODE_W = 12;
  localparam int NFIELD = 32;   // 4 addresses x 8 field slots

  localparam logic [2:0] ADDR_MSET = 3'd4;
  localparam logic [2:0] ADDR_MCLR = 3'd5;

  function automatic int num_src(int dma_ch, bit extra);
    return 11 + dma_ch + (extra ? 2 : 0);
  endfunction

  // flat field slot = address*8 + field
  function automatic int field_of(int i, int dma_ch);
    if (i < 4)              return i;
    else if (i < 7)         return 8 + (i - 4);
    else if (i < 11)        return 11;
    else if (i < 11+dma_ch) return 16;
    else                    return 24 + (i - 11 - dma_ch);
  endfunction

  function automatic bit field_live(int f, bit extra);
    return (f < 4) || (f >= 8 && f < 12) || (f == 16) ||
           (extra && (f == 24 || f == 25));
  endfunction

  function automatic logic [CODE_W-1:0] code_of(int i, int dma_ch);
    int r;
    if (i < 4) begin
      case (i)
        0: r = 'h240;
        1: r = 'h2A0;
        2: r = 'h300;
        default: r = 'h360;
      endcase
    end else if (i < 7)         r = 'h400 + 32*(i - 4);
    else if (i < 11)            r = 'h4E0 + 32*(i - 7);
    else if (i < 11+dma_ch) begin
      if (i - 11 < 4)           r = 'h640 + 32*(i - 11);
      else                      r = 'h780 + 32*(i - 15);
    end else if (i == 11+dma_ch) r = 'hB00;
    else                        r = 'hB80;
    return CODE_W'(r);
  endfunction

endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
  import gpic_pkg::*;
#(
  parameter int DMA_CH    = 4,
  parameter bit EXTRA_TMR = 1'b1,
  parameter int N         = 17
)(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [2:0]                     addr,
  input  logic [31:0]                    wdata,
  output logic [31:0]                    rdata,
  output logic [NFIELD-1:0][LVL_W-1:0]   prio_f,
  output logic [N-1:0]                   mask_q
);

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    if (field_live(f, EXTRA_TMR)) begin : g_live
      localparam logic [2:0] FADDR = 3'(f / 8);
      localparam int         FBIT  = (f % 8) * LVL_W;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          prio_f[f] <= '0;
        else if (we && addr == FADDR)
          prio_f[f] <= wdata[FBIT +: LVL_W];
      end
    end else begin : g_dead
      assign prio_f[f] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (we && addr == ADDR_MSET)
      mask_q <= mask_q | wdata[N-1:0];
    else if (we && addr == ADDR_MCLR)
      mask_q <= mask_q & ~wdata[N-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr <= 3'd3) begin
      for (int k = 0; k < 8; k++)
        rdata[k*LVL_W +: LVL_W] = prio_f[{addr[1:0], 3'(k)}];
    end else if (addr == ADDR_MSET || addr == ADDR_MCLR) begin
      rdata[N-1:0] = mask_q;
    end
  end

endmodule

// File: rtl/gpic_level_map.sv
module gpic_level_map
  import gpic_pkg::*;
#(
  parameter int DMA_CH = 4,
  parameter int N      = 17
)(
  input  logic [N-1:0]                  src,
  input  logic [N-1:0]                  mask,
  input  logic [NFIELD-1:0][LVL_W-1:0]  prio_f,
  output logic [N-1:0][LVL_W-1:0]       eff
);

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int F = field_of(i, DMA_CH);
    assign eff[i] = (src[i] && !mask[i]) ? prio_f[F] : '0;
  end

endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
  import gpic_pkg::*;
#(
  parameter int N  = 17,
  parameter int IW = $clog2(N)
)(
  input  logic [N-1:0][LVL_W-1:0] eff,
  output logic [LVL_W-1:0]        win_lvl,
  output logic [IW-1:0]           win_idx
);

  // strict compare keeps the lowest index on a tie
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (eff[i] > win_lvl) begin
        win_lvl = eff[i];
        win_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/gpic_top.sv
module gpic_top
  import gpic_pkg::*;
#(
  parameter int DMA_CH    = 4,
  parameter bit EXTRA_TMR = 1'b1
)(
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    reg_we,
  input  logic [2:0]                              reg_addr,
  input  logic [31:0]                             reg_wdata,
  output logic [31:0]                             reg_rdata,
  input  logic [num_src(DMA_CH, EXTRA_TMR)-1:0]   src_lvl,
  input  logic [3:0]                              cpu_mask,
  output logic                                    irq_req,
  output logic [3:0]                              irq_level,
  output logic [11:0]                             irq_code
);

  localparam int N_SRC = num_src(DMA_CH, EXTRA_TMR);
  localparam int IW    = $clog2(N_SRC);

  logic [NFIELD-1:0][LVL_W-1:0] prio_f;
  logic [N_SRC-1:0]             mask_vec;
  logic [N_SRC-1:0][LVL_W-1:0]  eff;
  logic [LVL_W-1:0]             win_lvl;
  logic [IW-1:0]                win_idx;
  logic [N_SRC-1:0][CODE_W-1:0] code_tab;
  logic [CODE_W-1:0]            win_code;

  gpic_regs #(.DMA_CH(DMA_CH), .EXTRA_TMR(EXTRA_TMR), .N(N_SRC)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .prio_f(prio_f),
    .mask_q(mask_vec)
  );

  gpic_level_map #(.DMA_CH(DMA_CH), .N(N_SRC)) u_map (
    .src   (src_lvl),
    .mask  (mask_vec),
    .prio_f(prio_f),
    .eff   (eff)
  );

  gpic_arbiter #(.N(N_SRC), .IW(IW)) u_arb (
    .eff    (eff),
    .win_lvl(win_lvl),
    .win_idx(win_idx)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_code
    assign code_tab[i] = code_of(i, DMA_CH);
  end

  assign win_code = code_tab[win_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_code  <= '0;
    end else begin
      irq_req   <= (win_lvl > cpu_mask);
      irq_level <= win_lvl;
      irq_code  <= (win_lvl == '0) ? '0 : win_code;
    end
  end

endmodule

// File: rtl/gpic_chk.sv
module gpic_chk #(
  parameter int N = 17
)(
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [2:0]   reg_addr,
  input logic [31:0]  reg_wdata,
  input logic [31:0]  reg_rdata,
  input logic [N-1:0] src_lvl,
  input logic [3:0]   cpu_mask,
  input logic         irq_req,
  input logic [3:0]   irq_level,
  input logic [11:0]  irq_code,
  input logic [N-1:0] mask_vec
);

  // R8: a request implies the level beats the mask sampled at the previous edge
  a_r8_req_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > $past(cpu_mask)));

  // R6: no winner means an idle output
  a_r6_idle_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 4'd0) |-> (!irq_req && irq_code == 12'd0));

  // R9: a winner needs a pending source one edge earlier
  a_r9_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 4'd0) |-> ($past(src_lvl) != '0));

  // R5: set and clear addresses act on the written ones
  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd4) |=>
      ((mask_vec & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0])));

  a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd5) |=> ((mask_vec & $past(reg_wdata[N-1:0])) == '0));

  // R2: narrow registers read zero in the upper half
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr <= 3'd2) |-> (reg_rdata[31:16] == 16'd0));

endmodule

bind gpic_top gpic_chk #(.N(N_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .src_lvl  (src_lvl),
  .cpu_mask (cpu_mask),
  .irq_req  (irq_req),
  .irq_level(irq_level),
  .irq_code (irq_code),
  .mask_vec (mask_vec)
);

// File: tb/gpic_top_tb.sv
module gpic_top_tb;

  localparam int N = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] src_lvl = '0;
  logic [3:0]  cpu_mask = '0;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic [11:0] irq_code;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0]   mf [32];
  logic [N-1:0] mmask;

  always #5 clk = ~clk;

  gpic_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lvl(src_lvl),
    .cpu_mask(cpu_mask), .irq_req(irq_req), .irq_level(irq_level),
    .irq_code(irq_code)
  );

  function automatic logic [11:0] ecode(int i);
    case (i)
      0: return 12'h240;  1: return 12'h2A0;  2: return 12'h300;
      3: return 12'h360;  4: return 12'h400;  5: return 12'h420;
      6: return 12'h440;  7: return 12'h4E0;  8: return 12'h500;
      9: return 12'h520;  10: return 12'h540; 11: return 12'h640;
      12: return 12'h660; 13: return 12'h680; 14: return 12'h6A0;
      15: return 12'hB00; default: return 12'hB80;
    endcase
  endfunction

  function automatic int efield(int i);
    if (i < 4) return i;
    if (i < 7) return 8 + i - 4;
    if (i < 11) return 11;
    if (i < 15) return 16;
    return 24 + i - 15;
  endfunction

  function automatic bit elive(int f);
    return f < 4 || (f >= 8 && f < 12) || f == 16 || f == 24 || f == 25;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a <= 3) begin
      for (int k = 0; k < 8; k++)
        if (elive(a*8 + k)) mf[a*8 + k] = d[k*4 +: 4];
    end else if (a == 4) mmask = mmask | d[N-1:0];
    else if (a == 5) mmask = mmask & ~d[N-1:0];
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic out_chk(string tag);
    logic [3:0]  bl;
    logic [11:0] bc;
    logic [3:0]  e;
    bl = '0; bc = '0;
    for (int i = 0; i < N; i++) begin
      e = (src_lvl[i] && !mmask[i]) ? mf[efield(i)] : 4'd0;
      if (e > bl) begin bl = e; bc = ecode(i); end
    end
    chk(irq_level == bl, {tag, " level"}, 32'(irq_level), 32'(bl));
    chk(irq_code == bc, {tag, " code"}, 32'(irq_code), 32'(bc));
    chk(irq_req == (bl > cpu_mask), {tag, " req"}, 32'(irq_req), 32'(bl > cpu_mask));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    for (int f = 0; f < 32; f++) mf[f] = '0;
    mmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_req == 0 && irq_level == 0 && irq_code == 0, "R1 outputs",
        {19'd0, irq_req, irq_level, irq_code}, 32'd0);
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 32'd0, "R1 register read");

    // R2 16-bit registers
    wr(3'd0, 32'hABCD_1234);
    rd_chk(3'd0, 32'h0000_1234, "R2 upper half dropped");
    // R3 unused fields
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk(3'd2, 32'h0000_000F, "R3 dead fields at address 2");
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk(3'd3, 32'h0000_00FF, "R3 dead fields at address 3");

    // R5 register behaviour
    wr(3'd4, 32'h0000_0005);
    rd_chk(3'd4, 32'h5, "R5 set read at 4");
    rd_chk(3'd5, 32'h5, "R5 set read at 5");
    wr(3'd5, 32'h0000_0001);
    rd_chk(3'd4, 32'h4, "R5 clear one bit");
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk(3'd4, 32'h0, "R5 clear all");

    // R4 / R10 source sweep at level 5
    wr(3'd0, 32'h5555); wr(3'd1, 32'h5555); wr(3'd2, 32'h5); wr(3'd3, 32'h55);
    cpu_mask = 4'd0;
    for (int i = 0; i < N; i++) begin
      src_lvl = '0; src_lvl[i] = 1'b1;
      settle();
      chk(irq_code == ecode(i), (i >= 15) ? "R10 extra timer code" : "R4 code",
          32'(irq_code), 32'(ecode(i)));
      chk(irq_level == 4'd5 && irq_req, "R4 level/req", 32'(irq_level), 32'd5);
    end

    // R4 group sharing: one field write moves all serial members
    wr(3'd1, 32'h9555);
    src_lvl = '0; src_lvl[8] = 1'b1; settle();
    chk(irq_level == 4'd9 && irq_code == 12'h500, "R4 group member 8",
        32'(irq_level), 32'd9);
    src_lvl = '0; src_lvl[10] = 1'b1; settle();
    chk(irq_level == 4'd9 && irq_code == 12'h540, "R4 group member 10",
        32'(irq_level), 32'd9);

    // R7 highest level wins over lower index
    src_lvl = '0; src_lvl[0] = 1'b1; src_lvl[8] = 1'b1; settle();
    chk(irq_code == 12'h500, "R7 higher level wins", 32'(irq_code), 32'h500);
    // R7 tie to lowest index
    src_lvl = '0; src_lvl[1] = 1'b1; src_lvl[2] = 1'b1; src_lvl[13] = 1'b1; settle();
    chk(irq_code == 12'h2A0, "R7 tie lowest index", 32'(irq_code), 32'h2A0);

    // R6 level zero disables
    wr(3'd0, 32'h5550);
    src_lvl = '0; src_lvl[0] = 1'b1; settle();
    chk(!irq_req && irq_level == 0 && irq_code == 0, "R6 zero level idle",
        {19'd0, irq_req, irq_level, irq_code}, 32'd0);
    src_lvl[1] = 1'b1; settle();
    chk(irq_code == 12'h2A0, "R6 zero level skipped", 32'(irq_code), 32'h2A0);

    // R8 cpu mask compare
    src_lvl = '0; src_lvl[8] = 1'b1; cpu_mask = 4'd9; settle();
    chk(!irq_req && irq_level == 9 && irq_code == 12'h500, "R8 equal no req",
        32'(irq_req), 32'd0);
    cpu_mask = 4'd8; settle();
    chk(irq_req == 1'b1, "R8 below req", 32'(irq_req), 32'd1);
    cpu_mask = 4'd15; settle();
    chk(irq_req == 1'b0, "R8 top mask", 32'(irq_req), 32'd0);
    cpu_mask = 4'd0;

    // R5 mask effect on arbitration
    src_lvl = '0; src_lvl[8] = 1'b1; src_lvl[4] = 1'b1;
    wr(3'd4, 32'h100); settle();
    chk(irq_code == 12'h400, "R5 masked source skipped", 32'(irq_code), 32'h400);
    wr(3'd5, 32'h100); settle();
    chk(irq_code == 12'h500, "R5 unmasked again", 32'(irq_code), 32'h500);

    // R9 one-edge latency
    @(negedge clk);
    src_lvl = '0; src_lvl[5] = 1'b1;
    #1;
    chk(irq_code == 12'h500, "R9 holds before edge", 32'(irq_code), 32'h500);
    @(posedge clk); #1;
    chk(irq_code == 12'h420, "R9 updates after one edge", 32'(irq_code), 32'h420);

    // R7 randomized sweep against the model
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = $urandom_range(0, 5);
      if (sel < 4) wr(3'(sel), $urandom);
      else if (sel == 4) wr(3'($urandom_range(4, 5)), $urandom);
      @(negedge clk);
      src_lvl = N'($urandom);
      cpu_mask = 4'($urandom);
      settle();
      out_chk("R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule